// File: doc/BRIEF.md
# Clock Root Configuration Register Block

This block holds the programmable settings of a single clock root: a configuration word (pre-divider, source select, mode) and the three counter values used by a fractional M/N divider. Software programs a shadow copy of each setting over a small single-cycle register bus. Programming the shadow copy has no effect on the running clock. The new values reach the divider only when software requests a commit.

A commit request sets an update flag that software reads back and polls. The block moves the whole shadow set into the active set at a moment that cannot shorten a clock pulse. That moment is a divider cycle boundary, or any cycle while the root is stopped. A wait counter forces the commit if no boundary arrives in time. The update flag clears in the same edge that loads the new values. Per-register change flags show which shadow registers differ from what is running. A force-on bit and a live root-off status bit sit beside the update flag in the command word.

The active set drives the divider datapath directly. The block also decodes the mode field to flag dual-edge (M/N counter) operation.

Top module: `clkcfg_root`

## Requirements
- R1: After reset, every shadow and active setting, the update flag, the force-on bit and all change flags are 0.
- R2: Writing the command word (address 0) with bit 0 set raises the update flag. The flag reads back as bit 0 and stays 1 until the commit edge, where it clears. Writing bit 0 as 0 neither raises nor cancels the flag.
- R3: While the root is running, a pending commit takes place only on a rising edge where `div_boundary` is sampled high, or on the forced edge of R5.
- R4: While the root is off, a pending commit takes place on the first rising edge after the request.
- R5: A pending commit always takes place no later than MAX_WAIT cycles after the update flag rises. The flag reads 1 for at most MAX_WAIT cycles.
- R6: The active outputs change only on a commit edge. At that edge all four active registers take the shadow values present before the edge.
- R7: Command bit 1 is a read/write force-on bit. `root_off` and command bit 31 are 1 exactly when neither force-on nor `root_req` is 1.
- R8: Command bits 4, 5, 6 and 7 are change flags for the configuration word, N, M and D. A flag is set when its shadow register is written with a value that differs from the value the active register holds after that edge. A flag stays set until a commit clears it.
- R9: The configuration word (address 1) keeps the pre-divider in bits DIV_W-1:0, the source select in bits 10:8 and the mode in bits 13:12. Its other bits read 0 and ignore writes. M, N and D (addresses 2, 3, 4) keep only bits MND_W-1:0.
- R10: `dual_edge` is 1 exactly when the active mode field equals 2.
- R11: Addresses 5 to 7 read 0 and ignore writes. Command bits other than 0, 1, 4 to 7 and 31 read 0. Writes to bits 4 to 7 and 31 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and commit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, same cycle |
| root_req | input | 1 | Hardware request to run the root |
| div_boundary | input | 1 | Divider reports a cycle boundary |
| root_off | output | 1 | Root output is stopped |
| act_prediv | output | DIV_W | Active pre-divider |
| act_src | output | 3 | Active source select |
| act_mode | output | 2 | Active mode |
| act_m | output | MND_W | Active M value |
| act_n | output | MND_W | Active N value |
| act_d | output | MND_W | Active D value |
| dual_edge | output | 1 | Active mode selects M/N operation |

## Verification
The bench builds the block with DIV_W=5 and MND_W=8, which gives a configuration mask of 0x371F and byte-wide counter values. It also uses MAX_WAIT=6. With that short limit, a forced commit after exactly six pending cycles falls within a few bus transactions, so the timeout path can be seen directly alongside the boundary path and the root-off path. Commits are driven with the root stopped, running, and held on by the force bit. Writes that repeat the running value are checked for not raising a change flag.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;
  localparam int CFG_W  = 14;

  localparam logic [ADDR_W-1:0] A_CMD = 3'd0;
  localparam logic [ADDR_W-1:0] A_CFG = 3'd1;
  localparam logic [ADDR_W-1:0] A_M   = 3'd2;
  localparam logic [ADDR_W-1:0] A_N   = 3'd3;
  localparam logic [ADDR_W-1:0] A_D   = 3'd4;

  localparam int SRC_LSB  = 8;
  localparam int SRC_W    = 3;
  localparam int MODE_LSB = 12;
  localparam int MODE_W   = 2;
  localparam logic [MODE_W-1:0] MODE_DUAL = 2'd2;

  // change-flag index inside the 4-bit flag vector (command bits 4..7)
  localparam int CHG_CFG = 0;
  localparam int CHG_N   = 1;
  localparam int CHG_M   = 2;
  localparam int CHG_D   = 3;

  localparam int CMD_UPD_BIT   = 0;
  localparam int CMD_FORCE_BIT = 1;

  // keep only the legal configuration bits
  function automatic logic [CFG_W-1:0] cfg_legal(input logic [DATA_W-1:0] w, input int div_w);
    logic [CFG_W-1:0] r;
    r = '0;
    for (int i = 0; i < CFG_W; i++) begin
      if (i < div_w || (i >= SRC_LSB && i < SRC_LSB + SRC_W) ||
          (i >= MODE_LSB && i < MODE_LSB + MODE_W))
        r[i] = w[i];
    end
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] cmd_word(input logic off, input logic [3:0] chg,
                                                 input logic force_on, input logic pend);
    logic [DATA_W-1:0] r;
    r = '0;
    r[31]  = off;
    r[7:4] = chg;
    r[CMD_FORCE_BIT] = force_on;
    r[CMD_UPD_BIT]   = pend;
    return r;
  endfunction
endpackage

// File: rtl/clkcfg_commit.sv
module clkcfg_commit #(
  parameter int MAX_WAIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic upd_req,
  input  logic div_boundary,
  input  logic root_off,
  output logic pending,
  output logic commit
);
  localparam int CW = $clog2(MAX_WAIT + 1);

  logic          pend_q;
  logic [CW-1:0] wait_q;
  logic          timeout;

  assign timeout = (wait_q == CW'(MAX_WAIT - 1));
  assign commit  = pend_q && (div_boundary || root_off || timeout);
  assign pending = pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      wait_q <= '0;
    end else begin
      pend_q <= upd_req || (pend_q && !commit);
      wait_q <= (pend_q && !commit) ? wait_q + 1'b1 : '0;
    end
  end

  assert_req_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    upd_req |=> pend_q);
  assert_hold_no_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !div_boundary && !root_off && !timeout) |=> pend_q);
  assert_off_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && root_off && !upd_req) |=> !pend_q);
  assert_wait_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> (wait_q < CW'(MAX_WAIT)));
endmodule

// File: rtl/clkcfg_shadow.sv
module clkcfg_shadow
  import clkcfg_pkg::*;
#(
  parameter int DIV_W = 5,
  parameter int MND_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              commit,
  input  logic [CFG_W-1:0]  act_cfg,
  input  logic [MND_W-1:0]  act_m,
  input  logic [MND_W-1:0]  act_n,
  input  logic [MND_W-1:0]  act_d,
  output logic [CFG_W-1:0]  sh_cfg,
  output logic [MND_W-1:0]  sh_m,
  output logic [MND_W-1:0]  sh_n,
  output logic [MND_W-1:0]  sh_d,
  output logic [3:0]        chg
);
  wire [3:0] chg_set;
  logic [3:0] chg_q;

  logic             cfg_hit;
  logic [CFG_W-1:0] cfg_wv;
  logic [CFG_W-1:0] cfg_nact;
  logic [CFG_W-1:0] cfg_q;

  assign cfg_hit  = wr_en && (addr == A_CFG);
  assign cfg_wv   = cfg_legal(wdata, DIV_W);
  assign cfg_nact = commit ? cfg_q : act_cfg;
  assign chg_set[CHG_CFG] = cfg_hit && (cfg_wv != cfg_nact);

  always_ff @(posedge clk) begin
    if (!rst_n)       cfg_q <= '0;
    else if (cfg_hit) cfg_q <= cfg_wv;
  end

  for (genvar g = 0; g < 3; g++) begin : g_mnd
    localparam logic [ADDR_W-1:0] RADDR = A_M + ADDR_W'(g);
    localparam int CI = (g == 0) ? CHG_M : (g == 1) ? CHG_N : CHG_D;
    logic             hit;
    logic [MND_W-1:0] wv;
    logic [MND_W-1:0] act_v;
    logic [MND_W-1:0] nact;
    logic [MND_W-1:0] q;
    assign hit   = wr_en && (addr == RADDR);
    assign wv    = wdata[MND_W-1:0];
    assign act_v = (g == 0) ? act_m : (g == 1) ? act_n : act_d;
    assign nact  = commit ? q : act_v;
    assign chg_set[CI] = hit && (wv != nact);
    always_ff @(posedge clk) begin
      if (!rst_n)   q <= '0;
      else if (hit) q <= wv;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) chg_q <= '0;
    else        chg_q <= (chg_q & ~{4{commit}}) | chg_set;
  end

  assign sh_cfg = cfg_q;
  assign sh_m   = g_mnd[0].q;
  assign sh_n   = g_mnd[1].q;
  assign sh_d   = g_mnd[2].q;
  assign chg    = chg_q;

  logic shadow_wr;
  assign shadow_wr = wr_en && (addr >= A_CFG) && (addr <= A_D);

  assert_chg_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !shadow_wr) |=> (chg_q == 4'd0));
  assert_chg_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ((chg_q & $past(chg_q)) == $past(chg_q)));
endmodule

// File: rtl/clkcfg_active.sv
module clkcfg_active
  import clkcfg_pkg::*;
#(
  parameter int MND_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [CFG_W-1:0] sh_cfg,
  input  logic [MND_W-1:0] sh_m,
  input  logic [MND_W-1:0] sh_n,
  input  logic [MND_W-1:0] sh_d,
  output logic [CFG_W-1:0] act_cfg,
  output logic [MND_W-1:0] act_m,
  output logic [MND_W-1:0] act_n,
  output logic [MND_W-1:0] act_d
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_cfg <= '0;
      act_m   <= '0;
      act_n   <= '0;
      act_d   <= '0;
    end else if (commit) begin
      act_cfg <= sh_cfg;
      act_m   <= sh_m;
      act_n   <= sh_n;
      act_d   <= sh_d;
    end
  end

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable({act_cfg, act_m, act_n, act_d}));
  assert_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> ({act_cfg, act_m, act_n, act_d} == $past({sh_cfg, sh_m, sh_n, sh_d})));
endmodule

// File: rtl/clkcfg_root.sv
module clkcfg_root
  import clkcfg_pkg::*;
#(
  parameter int DIV_W    = 5,
  parameter int MND_W    = 8,
  parameter int MAX_WAIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              root_req,
  input  logic              div_boundary,
  output logic              root_off,
  output logic [DIV_W-1:0]  act_prediv,
  output logic [2:0]        act_src,
  output logic [1:0]        act_mode,
  output logic [MND_W-1:0]  act_m,
  output logic [MND_W-1:0]  act_n,
  output logic [MND_W-1:0]  act_d,
  output logic              dual_edge
);
  logic             force_q;
  logic             cmd_wr;
  logic             upd_req;
  logic             pending;
  logic             commit;
  logic [3:0]       chg;
  logic [CFG_W-1:0] sh_cfg;
  logic [CFG_W-1:0] act_cfg;
  logic [MND_W-1:0] sh_m;
  logic [MND_W-1:0] sh_n;
  logic [MND_W-1:0] sh_d;

  assign cmd_wr   = bus_wr && (bus_addr == A_CMD);
  assign upd_req  = cmd_wr && bus_wdata[CMD_UPD_BIT];
  assign root_off = !(force_q || root_req);

  always_ff @(posedge clk) begin
    if (!rst_n)      force_q <= 1'b0;
    else if (cmd_wr) force_q <= bus_wdata[CMD_FORCE_BIT];
  end

  clkcfg_commit #(.MAX_WAIT(MAX_WAIT)) u_commit (
    .clk(clk), .rst_n(rst_n), .upd_req(upd_req), .div_boundary(div_boundary),
    .root_off(root_off), .pending(pending), .commit(commit)
  );

  clkcfg_shadow #(.DIV_W(DIV_W), .MND_W(MND_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .commit(commit), .act_cfg(act_cfg), .act_m(act_m), .act_n(act_n), .act_d(act_d),
    .sh_cfg(sh_cfg), .sh_m(sh_m), .sh_n(sh_n), .sh_d(sh_d), .chg(chg)
  );

  clkcfg_active #(.MND_W(MND_W)) u_active (
    .clk(clk), .rst_n(rst_n), .commit(commit), .sh_cfg(sh_cfg), .sh_m(sh_m),
    .sh_n(sh_n), .sh_d(sh_d), .act_cfg(act_cfg), .act_m(act_m), .act_n(act_n),
    .act_d(act_d)
  );

  assign act_prediv = act_cfg[DIV_W-1:0];
  assign act_src    = act_cfg[SRC_LSB +: SRC_W];
  assign act_mode   = act_cfg[MODE_LSB +: MODE_W];
  assign dual_edge  = (act_mode == MODE_DUAL);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CMD:   bus_rdata = cmd_word(root_off, chg, force_q, pending);
      A_CFG:   bus_rdata = DATA_W'(sh_cfg);
      A_M:     bus_rdata = DATA_W'(sh_m);
      A_N:     bus_rdata = DATA_W'(sh_n);
      A_D:     bus_rdata = DATA_W'(sh_d);
      default: bus_rdata = '0;
    endcase
  end

  assert_force_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> (root_off == !($past(bus_wdata[CMD_FORCE_BIT]) || root_req)));
  assert_flag_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !upd_req) |=> !pending);
endmodule

// File: tb/sim_clkcfg_root.sv
module sim_clkcfg_root;
  localparam int DIVW = 5;
  localparam int MNDW = 8;
  localparam int MAXW = 6;
  localparam logic [31:0] CFGMASK = 32'h0000_371F;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic root_req = 1'b0;
  logic div_boundary = 1'b0;
  logic root_off;
  logic [DIVW-1:0] act_prediv;
  logic [2:0] act_src;
  logic [1:0] act_mode;
  logic [MNDW-1:0] act_m, act_n, act_d;
  logic dual_edge;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  clkcfg_root #(.DIV_W(DIVW), .MND_W(MNDW), .MAX_WAIT(MAXW)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .root_req(root_req),
    .div_boundary(div_boundary), .root_off(root_off), .act_prediv(act_prediv),
    .act_src(act_src), .act_mode(act_mode), .act_m(act_m), .act_n(act_n),
    .act_d(act_d), .dual_edge(dual_edge)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_scfg, m_sm, m_sn, m_sd, m_acfg, m_am, m_an, m_ad;
  int m_wait;
  bit m_pend, m_force;
  bit [3:0] m_chg;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_scfg = 0; m_sm = 0; m_sn = 0; m_sd = 0;
      m_acfg = 0; m_am = 0; m_an = 0; m_ad = 0;
      m_wait = 0; m_pend = 0; m_force = 0; m_chg = 0;
    end else begin
      bit off, cm, upd;
      int ncfg, nm, nn, nd, v;
      bit [3:0] setc;
      off  = !(m_force || root_req);
      cm   = m_pend && (div_boundary || off || m_wait == MAXW - 1);
      ncfg = cm ? m_scfg : m_acfg;
      nm   = cm ? m_sm : m_am;
      nn   = cm ? m_sn : m_an;
      nd   = cm ? m_sd : m_ad;
      upd  = 0;
      setc = 0;
      if (bus_wr) begin
        case (bus_addr)
          3'd0: begin upd = bus_wdata[0]; m_force = bus_wdata[1]; end
          3'd1: begin v = int'(bus_wdata & CFGMASK); setc[0] = (v != ncfg); m_scfg = v; end
          3'd2: begin v = int'(bus_wdata[7:0]); setc[2] = (v != nm); m_sm = v; end
          3'd3: begin v = int'(bus_wdata[7:0]); setc[1] = (v != nn); m_sn = v; end
          3'd4: begin v = int'(bus_wdata[7:0]); setc[3] = (v != nd); m_sd = v; end
          default: ;
        endcase
      end
      m_chg  = (cm ? 4'd0 : m_chg) | setc;
      m_wait = (m_pend && !cm) ? m_wait + 1 : 0;
      m_pend = upd || (m_pend && !cm);
      m_acfg = ncfg; m_am = nm; m_an = nn; m_ad = nd;
    end
  end

  function automatic longint exp_rd(input int a);
    case (a)
      0: return longint'({!(m_force || root_req), 23'd0, m_chg, 2'd0, m_force, m_pend});
      1: return longint'(m_scfg);
      2: return longint'(m_sm);
      3: return longint'(m_sn);
      4: return longint'(m_sd);
      default: return 0;
    endcase
  endfunction

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R6 active cfg", {act_mode, 1'b0, act_src, 3'd0, act_prediv}, m_acfg);
      chk("R6 active m", act_m, m_am);
      chk("R6 active n", act_n, m_an);
      chk("R6 active d", act_d, m_ad);
      chk("R10 dual edge", dual_edge, ((m_acfg >> 12) & 3) == 2);
      chk("R7 root off", root_off, !(m_force || root_req));
      case (bus_addr)
        3'd0: chk("R2 cmd read", bus_rdata, exp_rd(0));
        3'd1: chk("R9 cfg read", bus_rdata, exp_rd(1));
        3'd2, 3'd3, 3'd4: chk("R9 mnd read", bus_rdata, exp_rd(int'(bus_addr)));
        default: chk("R11 undefined read", bus_rdata, 0);
      endcase
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #2;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    @(posedge clk); #2;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    int cnt;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    rd(3'd0, r); chk("R1 cmd after reset", r, 32'h8000_0000);
    rd(3'd1, r); chk("R1 cfg after reset", r, 0);
    chk("R1 active m after reset", act_m, 0);

    // root off: write settings, commit on next edge
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, r); chk("R9 cfg mask", r, 32'h0000_371F);
    rd(3'd0, r); chk("R8 cfg change flag", r, 32'h8000_0010);
    wr(3'd2, 32'h0000_01AB);
    rd(3'd2, r); chk("R9 m width", r, 32'h0000_00AB);
    wr(3'd0, 32'h1);
    rd(3'd0, r); chk("R2 update flag set", r, 32'h8000_0051);
    rd(3'd0, r); chk("R4 commit while off", r, 32'h8000_0000);
    chk("R6 m committed", act_m, 8'hAB);
    chk("R6 prediv committed", act_prediv, 5'h1F);
    chk("R10 mode 3 not dual", dual_edge, 0);

    // root running: wait for divider boundary
    root_req = 1'b1;
    wr(3'd3, 32'h12);
    wr(3'd0, 32'h1);
    idle(1);
    rd(3'd0, r); chk("R3 waits for boundary", r[0], 1);
    chk("R3 n held", act_n, 0);
    div_boundary = 1'b1;
    @(posedge clk); #2;
    div_boundary = 1'b0;
    rd(3'd0, r); chk("R3 commit on boundary", r[0], 0);
    chk("R3 n committed", act_n, 8'h12);

    // running with no boundary: forced commit
    wr(3'd4, 32'h55);
    wr(3'd0, 32'h1);
    cnt = 0;
    for (int i = 0; i < 20; i++) begin
      rd(3'd0, r);
      if (r[0]) cnt++;
      else break;
    end
    chk("R5 pending cycles", cnt, MAXW);
    chk("R5 d committed", act_d, 8'h55);

    // force-on, write of 0 to update bit
    root_req = 1'b0;
    wr(3'd0, 32'h2);
    rd(3'd0, r); chk("R7 force on status", r, 32'h0000_0002);
    chk("R2 zero write no request", r[0], 0);
    wr(3'd1, 32'h371F);
    rd(3'd0, r); chk("R8 same value no flag", r[7:4], 0);

    // mode 2 selects dual edge
    wr(3'd1, 32'h2000);
    wr(3'd0, 32'h3);
    idle(MAXW + 2);
    chk("R10 dual edge", dual_edge, 1);
    chk("R10 prediv cleared", act_prediv, 0);
    rd(3'd0, r); chk("R8 flags cleared", r[7:4], 0);

    // undefined addresses and read-only bits
    wr(3'd6, 32'hFFFF_FFFF);
    rd(3'd5, r); chk("R11 addr5", r, 0);
    rd(3'd6, r); chk("R11 addr6", r, 0);
    rd(3'd7, r); chk("R11 addr7", r, 0);
    wr(3'd0, 32'h7FFF_FFFC);
    rd(3'd0, r); chk("R11 read-only bits", r, 32'h8000_0000);
    root_req = 1'b1;
    rd(3'd0, r); chk("R7 running status", r[31], 0);

    idle(2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule